// File: doc/BRIEF.md
# Serial Synthesizer Configuration Port

This block is the receiving end of a three-wire serial link. A controller uses it to program two frequency synthesizers and a shared reference-edge setting. The controller holds the load line low and shifts 24 bits on the serial data pin, one bit per rising edge of the serial clock. The first 8 bits form an address and the next 16 bits form a data word, and each part is sent most significant bit first. Raising the load line then commits the frame.

A committed frame either writes a divider word for one of the two synthesizers or writes the control word, depending on its address. The divider word is split into an N divider, an S counter and an F counter. The control word carries one bit that selects which reference edge is used for comparison. Every write raises a one-cycle strobe for the register it touched, so the dividers downstream know when to reload.

The serial pins run slower than the system clock and are oversampled in the system clock domain. A frame whose length is wrong is dropped, and a sticky error flag is raised.

Top module: `synth_cfg_port`

## Requirements
- R1: A committed 24-bit frame with address 0x80 loads synthesizer 1 as follows: N from data bits 15..9, S from bits 8..5 and F from bits 4..0. The address is the first 8 bits shifted in and the data word is the last 16, each sent most significant bit first.
- R2: A committed frame with address 0x81 loads the same three fields into synthesizer 2. Synthesizer 1 and the control bit are left unchanged.
- R3: A committed frame with address 0x84 copies data bit 8 into `ref_edge_rise`, where 1 selects the rising edge and 0 the falling edge. No divider field changes.
- R4: A frame with any address other than 0x80, 0x81 or 0x84 changes no output and raises no strobe.
- R5: A commit happens only once per low-to-high transition of the load line. Holding the load line high does not repeat the commit.
- R6: A load rise that follows a number of serial clock rises other than 24 since the load line fell changes no register. It sets `frame_err`, which stays high until reset.
- R7: Each accepted write raises exactly one strobe, for the written register only, and that strobe is high for a single system clock cycle.
- R8: After reset, all divider fields are 0, `ref_edge_rise` is 1, `frame_err` is 0 and no strobe is high.
- R9: With all three serial pins resting high, as they do when left unconnected, no register changes and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, sent most significant bit first |
| ser_load | input | 1 | Load line; it is low while shifting and its rise commits the frame |
| syn1_n | output | 7 | Synthesizer 1 N divider |
| syn1_s | output | 4 | Synthesizer 1 S counter |
| syn1_f | output | 5 | Synthesizer 1 F counter |
| syn2_n | output | 7 | Synthesizer 2 N divider |
| syn2_s | output | 4 | Synthesizer 2 S counter |
| syn2_f | output | 5 | Synthesizer 2 F counter |
| ref_edge_rise | output | 1 | Reference comparison edge: 1 selects rising, 0 selects falling |
| syn1_upd | output | 1 | One-cycle strobe when synthesizer 1 is written |
| syn2_upd | output | 1 | One-cycle strobe when synthesizer 2 is written |
| ctl_upd | output | 1 | One-cycle strobe when the control word is written |
| frame_err | output | 1 | Sticky flag for a frame of the wrong length |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 16-bit data word split 7/4/5, and two synchronizer stages. With an 8-bit address, every one of the 256 addresses can be sent as a full frame. Each frame carries a data word computed from its address, so both divider decodes, the control bit and every reserved address are checked against an independently computed expected state. Frames of 23, 25 and 0 bits, a load line held high for a long time, and both values of the edge-select bit cover the error and single-commit rules.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  // Extract an unsigned bit field of a given width starting at a given lsb.
  function automatic int unsigned take_field(input logic [31:0] word,
                                             input int unsigned lsb,
                                             input int unsigned width);
    logic [31:0] mask;
    mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    return int'((word >> lsb) & mask);
  endfunction

  // True when v lies in [base, base+count).
  function automatic logic in_window(input int unsigned v,
                                     input int unsigned base,
                                     input int unsigned count);
    return (v >= base) && (v < base + count);
  endfunction

endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/synth_cfg_shifter.sv
module synth_cfg_shifter #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_in,
  input  logic               shift_en,
  input  logic               clear,
  output logic [FRAME_W-1:0] frame,
  output logic               full
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '0;
      cnt   <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (shift_en) begin
      frame <= {frame[FRAME_W-2:0], bit_in};
      if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
    end
  end

  assign full = (cnt == CNT_W'(FRAME_W));
endmodule

// File: rtl/synth_cfg_regs.sv
module synth_cfg_regs
  import synth_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int N_W = 7,
  parameter int S_W = 4,
  parameter int F_W = 5,
  parameter int NUM_SYN = 2,
  parameter int A_SYN_BASE = 'h80,
  parameter int A_CTL = 'h84,
  parameter int POL_BIT = 8,
  parameter logic POL_RST = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             data,
  output logic [NUM_SYN-1:0][N_W-1:0]   syn_n,
  output logic [NUM_SYN-1:0][S_W-1:0]   syn_s,
  output logic [NUM_SYN-1:0][F_W-1:0]   syn_f,
  output logic [NUM_SYN-1:0]            syn_upd,
  output logic                          pol,
  output logic                          ctl_upd,
  output logic                          addr_known
);
  localparam int S_LSB = F_W;
  localparam int N_LSB = F_W + S_W;

  logic [31:0] data_w;
  assign data_w = 32'(data);

  assign addr_known = in_window(int'(addr), A_SYN_BASE, NUM_SYN) ||
                      (int'(addr) == A_CTL);

  for (genvar k = 0; k < NUM_SYN; k++) begin : g_syn
    logic           hit;
    logic [N_W-1:0] n_q;
    logic [S_W-1:0] s_q;
    logic [F_W-1:0] f_q;
    logic           upd_q;

    assign hit = commit && (int'(addr) == A_SYN_BASE + k);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        n_q   <= '0;
        s_q   <= '0;
        f_q   <= '0;
        upd_q <= 1'b0;
      end else begin
        upd_q <= hit;
        if (hit) begin
          n_q <= N_W'(take_field(data_w, N_LSB, N_W));
          s_q <= S_W'(take_field(data_w, S_LSB, S_W));
          f_q <= F_W'(take_field(data_w, 0, F_W));
        end
      end
    end

    assign syn_n[k]   = n_q;
    assign syn_s[k]   = s_q;
    assign syn_f[k]   = f_q;
    assign syn_upd[k] = upd_q;
  end

  logic ctl_hit;
  assign ctl_hit = commit && (int'(addr) == A_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol     <= POL_RST;
      ctl_upd <= 1'b0;
    end else begin
      ctl_upd <= ctl_hit;
      if (ctl_hit) pol <= data[POL_BIT];
    end
  end
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int N_W = 7,
  parameter int S_W = 4,
  parameter int F_W = 5,
  parameter int SYNC_STAGES = 2,
  parameter int A_SYN_BASE = 'h80,
  parameter int A_CTL = 'h84,
  parameter int POL_BIT = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  output logic [N_W-1:0] syn1_n,
  output logic [S_W-1:0] syn1_s,
  output logic [F_W-1:0] syn1_f,
  output logic [N_W-1:0] syn2_n,
  output logic [S_W-1:0] syn2_s,
  output logic [F_W-1:0] syn2_f,
  output logic           ref_edge_rise,
  output logic           syn1_upd,
  output logic           syn2_upd,
  output logic           ctl_upd,
  output logic           frame_err
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int NUM_SYN = 2;

  // Synchronized pin levels; idle-high reset avoids a spurious edge.
  logic load_s, sclk_s, data_s;
  synth_cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ser_load, ser_clk, ser_data}),
    .q    ({load_s, sclk_s, data_s})
  );

  logic sclk_d, load_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b1;
      load_d <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      load_d <= load_s;
    end
  end

  logic sclk_rise, load_rise;
  assign sclk_rise = sclk_s & ~sclk_d;
  assign load_rise = load_s & ~load_d;

  logic [FRAME_W-1:0] frame;
  logic               frame_full;
  synth_cfg_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_in  (data_s),
    .shift_en(sclk_rise),
    .clear   (load_s),
    .frame   (frame),
    .full    (frame_full)
  );

  logic commit_ok, commit_bad, commit_rsv, addr_known;
  assign commit_ok  = load_rise & frame_full;
  assign commit_bad = load_rise & ~frame_full;
  assign commit_rsv = commit_ok & ~addr_known;

  logic [NUM_SYN-1:0][N_W-1:0] syn_n;
  logic [NUM_SYN-1:0][S_W-1:0] syn_s;
  logic [NUM_SYN-1:0][F_W-1:0] syn_f;
  logic [NUM_SYN-1:0]          syn_upd;

  synth_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_W(N_W), .S_W(S_W), .F_W(F_W),
    .NUM_SYN(NUM_SYN), .A_SYN_BASE(A_SYN_BASE), .A_CTL(A_CTL),
    .POL_BIT(POL_BIT), .POL_RST(1'b1)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit_ok),
    .addr      (frame[FRAME_W-1 -: ADDR_W]),
    .data      (frame[DATA_W-1:0]),
    .syn_n     (syn_n),
    .syn_s     (syn_s),
    .syn_f     (syn_f),
    .syn_upd   (syn_upd),
    .pol       (ref_edge_rise),
    .ctl_upd   (ctl_upd),
    .addr_known(addr_known)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_err <= 1'b0;
    else if (commit_bad) frame_err <= 1'b1;
  end

  assign syn1_n   = syn_n[0];
  assign syn1_s   = syn_s[0];
  assign syn1_f   = syn_f[0];
  assign syn2_n   = syn_n[1];
  assign syn2_s   = syn_s[1];
  assign syn2_f   = syn_f[1];
  assign syn1_upd = syn_upd[0];
  assign syn2_upd = syn_upd[1];
endmodule

// File: rtl/synth_cfg_port_chk.sv
module synth_cfg_port_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_rise,
  input logic              commit_ok,
  input logic              commit_rsv,
  input logic              syn1_upd,
  input logic              syn2_upd,
  input logic              ctl_upd,
  input logic              frame_err,
  input logic [WORD_W-1:0] syn1_word,
  input logic [WORD_W-1:0] syn2_word,
  input logic              ref_edge_rise
);
  logic any_upd;
  assign any_upd = syn1_upd | syn2_upd | ctl_upd;

  assert_syn1_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(syn1_word) |-> syn1_upd);

  assert_syn2_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(syn2_word) |-> syn2_upd);

  assert_pol_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_edge_rise) |-> ctl_upd);

  assert_reserved_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_rsv |=> !any_upd);

  assert_upd_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_upd |-> $past(commit_ok));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> $past(load_rise && !commit_ok));

  assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({syn1_upd, syn2_upd, ctl_upd}));

  assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_upd |=> !any_upd);
endmodule

bind synth_cfg_port synth_cfg_port_chk #(.WORD_W(N_W + S_W + F_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_rise    (load_rise),
  .commit_ok    (commit_ok),
  .commit_rsv   (commit_rsv),
  .syn1_upd     (syn1_upd),
  .syn2_upd     (syn2_upd),
  .ctl_upd      (ctl_upd),
  .frame_err    (frame_err),
  .syn1_word    ({syn1_n, syn1_s, syn1_f}),
  .syn2_word    ({syn2_n, syn2_s, syn2_f}),
  .ref_edge_rise(ref_edge_rise)
);

// File: tb/sim_synth_cfg_port.sv
`timescale 1ns/1ps
module sim_synth_cfg_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b1, ser_data = 1'b1, ser_load = 1'b1;
  logic [6:0] syn1_n, syn2_n;
  logic [3:0] syn1_s, syn2_s;
  logic [4:0] syn1_f, syn2_f;
  logic ref_edge_rise, syn1_upd, syn2_upd, ctl_upd, frame_err;

  always #2 clk = ~clk;

  synth_cfg_port u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .syn1_n(syn1_n), .syn1_s(syn1_s), .syn1_f(syn1_f),
    .syn2_n(syn2_n), .syn2_s(syn2_s), .syn2_f(syn2_f),
    .ref_edge_rise(ref_edge_rise), .syn1_upd(syn1_upd), .syn2_upd(syn2_upd),
    .ctl_upd(ctl_upd), .frame_err(frame_err)
  );

  int n_chk = 0, n_fail = 0;
  int c1 = 0, c2 = 0, cc = 0;
  bit done = 1'b0;

  int e_n[2], e_s[2], e_f[2];
  int e_pol = 1;
  int e_err = 0;

  always @(negedge clk) begin
    if (syn1_upd) c1++;
    if (syn2_upd) c2++;
    if (ctl_upd) cc++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] word, input int nbits, input int hold);
    c1 = 0; c2 = 0; cc = 0;
    @(negedge clk);
    ser_load = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_clk = 1'b0;
      ser_data = word[i];
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
    end
    ser_data = 1'b1;
    repeat (4) @(negedge clk);
    ser_load = 1'b1;
    repeat (16 + hold) @(negedge clk);
  endtask

  // Compare full state and strobe counts against the model.
  task automatic check_all(input string req, input int x1, input int x2, input int xc);
    chk(syn1_n == 7'(e_n[0]), {req, " syn1_n"}, int'(syn1_n), e_n[0]);
    chk(syn1_s == 4'(e_s[0]), {req, " syn1_s"}, int'(syn1_s), e_s[0]);
    chk(syn1_f == 5'(e_f[0]), {req, " syn1_f"}, int'(syn1_f), e_f[0]);
    chk(syn2_n == 7'(e_n[1]), {req, " syn2_n"}, int'(syn2_n), e_n[1]);
    chk(syn2_s == 4'(e_s[1]), {req, " syn2_s"}, int'(syn2_s), e_s[1]);
    chk(syn2_f == 5'(e_f[1]), {req, " syn2_f"}, int'(syn2_f), e_f[1]);
    chk(ref_edge_rise == 1'(e_pol), {req, " pol"}, int'(ref_edge_rise), e_pol);
    chk(frame_err == 1'(e_err), {req, " frame_err"}, int'(frame_err), e_err);
    chk(c1 == x1, {req, " syn1 strobes"}, c1, x1);
    chk(c2 == x2, {req, " syn2 strobes"}, c2, x2);
    chk(cc == xc, {req, " ctl strobes"}, cc, xc);
  endtask

  function automatic void model(input int a, input int d);
    if (a == 128 || a == 129) begin
      e_n[a - 128] = d / 512;
      e_s[a - 128] = (d / 32) % 16;
      e_f[a - 128] = d % 32;
    end else if (a == 132) begin
      e_pol = (d / 256) % 2;
    end
  endfunction

  function automatic string tag_of(input int a);
    if (a == 128) return "R1";
    if (a == 129) return "R2";
    if (a == 132) return "R3";
    return "R4";
  endfunction

  initial begin
    for (int k = 0; k < 2; k++) begin e_n[k] = 0; e_s[k] = 0; e_f[k] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R8: reset state
    check_all("R8", 0, 0, 0);
    // R9: pins resting high for a while change nothing
    repeat (60) @(negedge clk);
    check_all("R9", 0, 0, 0);

    // Sweep every address with an address-derived data word (R1 R2 R3 R4, R7)
    for (int a = 0; a < 256; a++) begin
      int d;
      d = ((a * 40503) ^ 'h5A3C) % 65536;
      send(32'((a * 65536) + d), 24, 0);
      model(a, d);
      check_all(tag_of(a), (a == 128) ? 1 : 0, (a == 129) ? 1 : 0, (a == 132) ? 1 : 0);
    end

    // R3: both polarities explicitly
    send(32'h84_0000, 24, 0); model(132, 0);
    check_all("R3 falling", 0, 0, 1);
    send(32'h84_0100, 24, 0); model(132, 256);
    check_all("R3 rising", 0, 0, 1);

    // R5: load held high for long, commit only once
    send(32'h80_FFFF, 24, 200); model(128, 'hFFFF);
    check_all("R5 long hold", 1, 0, 0);

    // R6: short frame dropped, error set
    send(32'h81_1234 >> 1, 23, 0); e_err = 1;
    check_all("R6 short frame", 0, 0, 0);
    // R6: long frame dropped
    send({7'd0, 1'b1, 24'h81_4321}, 25, 0);
    check_all("R6 long frame", 0, 0, 0);
    // R6: bare load pulse
    send(32'h0, 0, 0);
    check_all("R6 empty frame", 0, 0, 0);
    // R6: good frame still accepted, error stays sticky
    send(32'h81_0ACE, 24, 0); model(129, 'h0ACE);
    check_all("R6 sticky R2", 0, 1, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule